// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sets the power state of a small microcontroller. Software writes a 3-bit mode code with a strobe. The block then drives a 10-bit vector of enables for the CPU, the clock domains, the frequency-lock loop, the oscillator stages, the core regulator and the real-time clock. Each of the eight modes has its own fixed gating pattern. The enable vector comes from a register, so an enable changes only on a clock edge.

In the five retention modes (codes 1 to 5), a pending interrupt brings the block to full activity for service. On return from interrupt it goes back to the stored mode, and software can rewrite that stored mode while the interrupt is being serviced. The two regulator-off modes (codes 6 and 7) ignore interrupts. They wake only from a short list of sources, and they leave through a core reset pulse of fixed length before full activity resumes.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset, en_o is 10'h3FF, mode_o is 0 and core_rst_o is 0.
- R2: Mode codes are: 0 active, 1 LPM0, 2 LPM1, 3 LPM2, 4 LPM3, 5 LPM4, 6 LPM3.5, 7 LPM4.5. The en_o bit positions are: 0 cpu, 1 main clock, 2 subsystem clock, 3 auxiliary clock, 4 FLL loop, 5 DCO clock, 6 DCO DC generator, 7 crystal, 8 core regulator, 9 RTC. The resulting patterns are 3FF, 3FC, 3EC, 3C8, 388, 100, 280 and 000 for codes 0 to 7.
- R3: While active, a write with mode_wr_i high and a nonzero mode_i takes effect at the next clock edge: mode_o and en_o change together at that edge. While mode_wr_i is low, mode_i has no effect.
- R4: In modes 1 to 5, irq_pend_i high wakes the block at the next edge. mode_o becomes 0 and en_o becomes 3FF.
- R5: During interrupt service, reti_i returns the block at the next edge to the stored mode and its pattern.
- R6: A mode write during service replaces the stored mode. If the stored mode is 0, reti_i leaves the block active.
- R7: A write, or a reti_i, that targets a low-power mode while a wake source that qualifies for that mode is pending leaves the block active.
- R8: Mode 6 wakes on wk_ext_i, wk_rtc_i, wk_pa_i or wk_pb_i, and ignores irq_pend_i.
- R9: Mode 7 wakes on wk_ext_i, wk_pa_i or wk_pb_i, and ignores irq_pend_i and wk_rtc_i.
- R10: A wake from mode 6 or 7 holds core_rst_o high with en_o = 3FE for RST_CYCLES cycles (4 by default). The block then becomes active with en_o = 3FF and core_rst_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code to write |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| reti_i | input | 1 | Return from interrupt |
| wk_ext_i | input | 1 | External reset/NMI pin wake |
| wk_rtc_i | input | 1 | RTC event wake |
| wk_pa_i | input | 1 | Port group A wake |
| wk_pb_i | input | 1 | Port group B wake |
| en_o | output | 10 | Registered enable vector |
| core_rst_o | output | 1 | Core reset pulse after a deep wake |
| mode_o | output | 3 | Mode whose pattern is applied |

## Verification
The assertions assume that mode_wr_i and reti_i are single-cycle pulses and are never raised together. They also assume that reti_i arrives only while an interrupt is being serviced. A write or return that meets a pending qualifying wake source is taken to be a no-op. The bench drives each strobe for exactly one cycle, on the falling edge. It clears irq_pend_i before each return, except where it tests the blocked entry on purpose. In a regulator-off mode it raises wake sources one at a time, so each source's effect can be seen on its own.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 3;
  localparam int EN_W   = 10;

  localparam logic [MODE_W-1:0] M_ACT  = 3'd0;
  localparam logic [MODE_W-1:0] M_LPM0 = 3'd1;
  localparam logic [MODE_W-1:0] M_LPM1 = 3'd2;
  localparam logic [MODE_W-1:0] M_LPM2 = 3'd3;
  localparam logic [MODE_W-1:0] M_LPM3 = 3'd4;
  localparam logic [MODE_W-1:0] M_LPM4 = 3'd5;
  localparam logic [MODE_W-1:0] M_D35  = 3'd6;
  localparam logic [MODE_W-1:0] M_D45  = 3'd7;

  localparam int B_CPU = 0, B_MCLK = 1, B_SMCLK = 2, B_ACLK = 3, B_FLL = 4;
  localparam int B_DCO = 5, B_DCGEN = 6, B_XTAL = 7, B_VREG = 8, B_RTC = 9;

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_SVC, S_WRST} st_t;

  function automatic logic is_deep(input logic [MODE_W-1:0] m);
    return (m == M_D35) || (m == M_D45);
  endfunction
endpackage

// File: rtl/lpm_gate_map.sv
module lpm_gate_map
  import lpm_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wrst_i,
  output logic [EN_W-1:0]   en_o
);
  always_comb begin
    en_o = '1;
    if (wrst_i) begin
      en_o[B_CPU] = 1'b0;
    end else begin
      unique case (mode_i)
        M_ACT: ;
        M_LPM0: begin
          en_o[B_CPU] = 1'b0; en_o[B_MCLK] = 1'b0;
        end
        M_LPM1: begin
          en_o[B_CPU] = 1'b0; en_o[B_MCLK] = 1'b0; en_o[B_FLL] = 1'b0;
        end
        M_LPM2: begin
          en_o[B_CPU] = 1'b0; en_o[B_MCLK] = 1'b0; en_o[B_SMCLK] = 1'b0;
          en_o[B_FLL] = 1'b0; en_o[B_DCO] = 1'b0;
        end
        M_LPM3: begin
          en_o[B_CPU] = 1'b0; en_o[B_MCLK] = 1'b0; en_o[B_SMCLK] = 1'b0;
          en_o[B_FLL] = 1'b0; en_o[B_DCO] = 1'b0; en_o[B_DCGEN] = 1'b0;
        end
        M_LPM4: begin
          en_o = '0;
          en_o[B_VREG] = 1'b1;
        end
        M_D35: begin
          en_o = '0;
          en_o[B_RTC] = 1'b1; en_o[B_XTAL] = 1'b1;
        end
        default: en_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_pend_i,
  input  logic              wk_ext_i,
  input  logic              wk_rtc_i,
  input  logic              wk_pa_i,
  input  logic              wk_pb_i,
  output logic              wake_o
);
  logic pin_wk;
  assign pin_wk = wk_ext_i | wk_pa_i | wk_pb_i;

  always_comb begin
    unique case (mode_i)
      M_ACT:   wake_o = 1'b0;
      M_D35:   wake_o = pin_wk | wk_rtc_i;
      M_D45:   wake_o = pin_wk;
      default: wake_o = irq_pend_i;
    endcase
  end
endmodule

// File: rtl/lpm_rst_timer.sv
module lpm_rst_timer #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(RST_CYCLES) + 1;
  localparam logic [CW-1:0] LOAD_V = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= LOAD_V;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_V);
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_pend_i,
  input  logic              reti_i,
  input  logic              wk_ext_i,
  input  logic              wk_rtc_i,
  input  logic              wk_pa_i,
  input  logic              wk_pb_i,
  output logic [EN_W-1:0]   en_o,
  output logic              core_rst_o,
  output logic [MODE_W-1:0] mode_o
);
  st_t               st_q, st_d;
  logic [MODE_W-1:0] cur_q, cur_d, sav_q, sav_d, tgt_mode;
  logic              wake_cur, wake_tgt, tmr_done;
  logic [EN_W-1:0]   en_d, en_q;
  logic              crst_q;

  assign tgt_mode = mode_wr_i ? mode_i : sav_q;

  lpm_wake_qual i_wq_cur (
    .mode_i(cur_q), .irq_pend_i, .wk_ext_i, .wk_rtc_i, .wk_pa_i, .wk_pb_i,
    .wake_o(wake_cur));

  lpm_wake_qual i_wq_tgt (
    .mode_i(tgt_mode), .irq_pend_i, .wk_ext_i, .wk_rtc_i, .wk_pa_i, .wk_pb_i,
    .wake_o(wake_tgt));

  lpm_rst_timer #(.RST_CYCLES(RST_CYCLES)) i_tmr (
    .clk_i, .rst_ni,
    .load_i(st_q != S_WRST && st_d == S_WRST),
    .run_i (st_q == S_WRST),
    .done_o(tmr_done));

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    sav_d = sav_q;
    unique case (st_q)
      S_RUN:
        if (mode_wr_i && mode_i != M_ACT && !wake_tgt) begin
          st_d  = S_SLEEP;
          cur_d = mode_i;
        end
      S_SLEEP:
        if (wake_cur) begin
          cur_d = M_ACT;
          if (is_deep(cur_q)) begin
            st_d = S_WRST;
          end else begin
            st_d  = S_SVC;
            sav_d = cur_q;
          end
        end
      S_SVC:
        if (mode_wr_i) begin
          sav_d = mode_i;
        end else if (reti_i) begin
          if (sav_q != M_ACT && !wake_tgt) begin
            st_d  = S_SLEEP;
            cur_d = sav_q;
          end else begin
            st_d = S_RUN;
          end
        end
      default:
        if (tmr_done) st_d = S_RUN;
    endcase
  end

  lpm_gate_map i_map (.mode_i(cur_d), .wrst_i(st_d == S_WRST), .en_o(en_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_RUN;
      cur_q  <= M_ACT;
      sav_q  <= M_ACT;
      en_q   <= '1;
      crst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      sav_q  <= sav_d;
      en_q   <= en_d;
      crst_q <= (st_d == S_WRST);
    end
  end

  assign en_o       = en_q;
  assign core_rst_o = crst_q;
  assign mode_o     = cur_q;

  assert_active_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_ACT && !core_rst_o) |-> en_o == '1);

  assert_rst_pulse_pattern_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (en_o[B_VREG] && !en_o[B_CPU] && mode_o == M_ACT));

  assert_blocked_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RUN && mode_wr_i && wake_tgt) |=> mode_o == M_ACT);

  assert_shallow_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SLEEP && !is_deep(cur_q) && irq_pend_i) |=> (mode_o == M_ACT && en_o == '1));

  assert_deep_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SLEEP && cur_q == M_D45 && !wk_ext_i && !wk_pa_i && !wk_pb_i)
      |=> (mode_o == M_D45 && en_o == '0));

  assert_reti_restore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SVC && reti_i && !mode_wr_i && sav_q != M_ACT && !wake_tgt)
      |=> mode_o == $past(sav_q));

  assert_wake_to_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SLEEP && cur_q == M_D35 && wk_rtc_i) |=> core_rst_o);
endmodule

// File: tb/test_lpm_clk_ctrl.sv
module test_lpm_clk_ctrl;
  localparam int RSTC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 0, irq = 0, reti = 0, wk_ext = 0, wk_rtc = 0, wk_pa = 0, wk_pb = 0;
  logic [2:0] mode_in = '0;
  logic [9:0] en;
  logic       crst;
  logic [2:0] mode_out;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl #(.RST_CYCLES(RSTC)) i_lpm_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_i(mode_in),
    .irq_pend_i(irq), .reti_i(reti), .wk_ext_i(wk_ext), .wk_rtc_i(wk_rtc),
    .wk_pa_i(wk_pa), .wk_pb_i(wk_pb), .en_o(en), .core_rst_o(crst), .mode_o(mode_out));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [9:0] en_x, input logic [2:0] m_x,
                     input logic r_x);
    total++;
    if (en !== en_x || mode_out !== m_x || crst !== r_x) begin
      bad++;
      $display("FAIL %s: en=%h mode=%0d rst=%b expected en=%h mode=%0d rst=%b",
               req, en, mode_out, crst, en_x, m_x, r_x);
    end
  endtask

  task automatic wr(input logic [2:0] m);
    mode_wr = 1; mode_in = m; step(); mode_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1", 10'h3FF, 3'd0, 1'b0);
  endtask

  task automatic t_no_strobe();
    mode_in = 3'd3; step(); chk("R3 no strobe", 10'h3FF, 3'd0, 1'b0);
  endtask

  task automatic t_shallow(input logic [2:0] m, input logic [9:0] pat);
    wr(m);             chk("R2/R3 enter", pat, m, 1'b0);
    step();            chk("R4 idle hold", pat, m, 1'b0);
    irq = 1; step();   irq = 0; chk("R4 wake", 10'h3FF, 3'd0, 1'b0);
    reti = 1; step();  reti = 0; chk("R5 return", pat, m, 1'b0);
    irq = 1; step();   irq = 0;
    wr(3'd0);
    reti = 1; step();  reti = 0; chk("R6 stay active", 10'h3FF, 3'd0, 1'b0);
  endtask

  task automatic t_rewrite_saved();
    wr(3'd1);
    irq = 1; step(); irq = 0;
    wr(3'd5);
    reti = 1; step(); reti = 0; chk("R6 new saved", 10'h100, 3'd5, 1'b0);
    irq = 1; step(); irq = 0;
    wr(3'd0); reti = 1; step(); reti = 0;
  endtask

  task automatic t_block();
    irq = 1; wr(3'd2); chk("R7 irq pending", 10'h3FF, 3'd0, 1'b0);
    irq = 0;
    wk_pa = 1; wr(3'd6); chk("R7 pin pending", 10'h3FF, 3'd0, 1'b0);
    wk_pa = 0;
    wr(3'd2); irq = 1; step(); irq = 1; reti = 1; step(); reti = 0; irq = 0;
    chk("R7 reti blocked", 10'h3FF, 3'd0, 1'b0);
  endtask

  task automatic drain_rst();
    for (int i = 1; i < RSTC; i++) begin
      step(); chk("R10 pulse", 10'h3FE, 3'd0, 1'b1);
    end
    step(); chk("R10 release", 10'h3FF, 3'd0, 1'b0);
  endtask

  task automatic t_d35();
    wr(3'd6);          chk("R2 mode6", 10'h280, 3'd6, 1'b0);
    irq = 1; step();   irq = 0; chk("R8 irq ignored", 10'h280, 3'd6, 1'b0);
    wk_rtc = 1; step(); wk_rtc = 0; chk("R8 rtc wake", 10'h3FE, 3'd0, 1'b1);
    drain_rst();
    wr(3'd6); wk_ext = 1; step(); wk_ext = 0; chk("R8 ext wake", 10'h3FE, 3'd0, 1'b1);
    drain_rst();
  endtask

  task automatic t_d45();
    wk_rtc = 1; wr(3'd7); chk("R9 enter with rtc", 10'h000, 3'd7, 1'b0);
    step();            chk("R9 rtc ignored", 10'h000, 3'd7, 1'b0);
    wk_rtc = 0;
    irq = 1; step();   irq = 0; chk("R9 irq ignored", 10'h000, 3'd7, 1'b0);
    wk_pb = 1; step(); wk_pb = 0; chk("R9 pin wake", 10'h3FE, 3'd0, 1'b1);
    drain_rst();
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        rst_n = 1; step();
        t_reset();
        t_no_strobe();
        t_shallow(3'd1, 10'h3FC);
        t_shallow(3'd2, 10'h3EC);
        t_shallow(3'd3, 10'h3C8);
        t_shallow(3'd4, 10'h388);
        t_shallow(3'd5, 10'h100);
        t_rewrite_saved();
        t_block();
        t_d35();
        t_d45();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule